// File: doc/BRIEF.md
# Successive-Approximation ADC Serial Readout Controller

This block is a synchronous master for a 12-bit successive-approximation converter reached over a three-wire serial link: an active-low select, a serial clock, a command line toward the converter and a result line back from it. For each conversion it lowers the select, waits a set number of system clocks, and then produces exactly 18 serial clock pulses. The serial clock is derived from the system clock through a half-period divider that is clamped between a fastest and a slowest allowed rate. The controller shifts a four-bit command pattern out, most significant bit first, on the first four rising edges. It drops the leading null bit and then collects twelve result bits, most significant bit first. The result is returned as an unsigned straight-binary word with a one-cycle valid strobe.

Both clock polarities are supported: idle-low and idle-high. In both, the controller launches data on falling edges and samples on rising edges. Between frames the select stays high for at least a programmed disable time. A new frame starts from the start input or from an internal sample-rate timer.

Top module: `sar_link_ctrl`

## Requirements
- R1: The serial clock half-period equals half_div clamped to the range [MIN_HALF, MAX_HALF] system cycles, latched at frame start. Successive rising edges within a frame are exactly twice that many cycles apart.
- R2: Every frame contains exactly 18 rising serial-clock edges. While select is high, sclk rests at the level of cpol (0 = idle low, 1 = idle high).
- R3: After reset, cs_n is 1, busy is 0 and result_valid is 0. In a frame, cs_n stays low for S + 36*H system cycles, where S = max(cs_setup,1) and H is the clamped half-period. The first rising edge comes S + H cycles after cs_n falls.
- R4: On rising edges 1 to 4, mosi carries cmd[3], cmd[2], cmd[1], cmd[0] in that order. While select is low, mosi changes only in the cycle in which sclk falls.
- R5: Miso sampled at rising edge 5 (the null bit) is discarded. The bits sampled at rising edges 6 to 17 form result[11] down to result[0], unaltered.
- R6: result_valid is high for exactly one cycle per frame, in the same cycle in which cs_n returns high. result changes only at that point.
- R7: Between two frames, cs_n stays high for at least G + 1 cycles, where G = max(cs_gap,1). With start held high, the gap is exactly G + 1.
- R8: busy is high from the cycle cs_n falls through the end of the disable gap. A start pulse while busy is high starts no frame.
- R9: With auto_en = 1 and start = 0, consecutive select falling edges are max(rate_period, S + 36*H + G + 1) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame (taken only when idle) |
| auto_en | input | 1 | Enable self-retriggering at rate_period |
| cpol | input | 1 | Serial clock idle level |
| half_div | input | HALF_W | Requested half-period in system cycles |
| cs_setup | input | CNT_W | Cycles from select low to first clock activity |
| cs_gap | input | CNT_W | Minimum select-high cycles after a frame |
| rate_period | input | RATE_W | Frame start spacing in auto mode |
| cmd | input | CMD_W | Command pattern, sent MSB first |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter |
| cs_n | output | 1 | Active-low select / shutdown control |
| mosi | output | 1 | Serial command to the converter |
| busy | output | 1 | Frame or disable gap in progress |
| result | output | DATA_W | Captured conversion code |
| result_valid | output | 1 | One-cycle strobe with a new result |

## Verification
Each result has a fixed latency. The select falls in the cycle after start is seen. The first rising edge follows S + H cycles later, and the valid strobe with the select rising edge follows S + 36*H cycles after the select falls. In auto mode, the next select fall comes max(rate_period, frame + G + 1) cycles after the previous one. A monitor samples on the falling system-clock edge and timestamps every select and serial-clock transition. The checks compare these cycle differences with the formulas above, worked out from the clamped half-period in the bench. A responder model drives the null bit and a known code, and records the command bits, in both clock polarities.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_SETUP = 2'd1,
    LK_RUN   = 2'd2,
    LK_GAP   = 2'd3
  } link_state_e;

  // Clamp a requested value into [lo, hi].
  function automatic int unsigned clamp_u(input int unsigned v,
                                          input int unsigned lo,
                                          input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Zero-length windows are promoted to one cycle.
  function automatic int unsigned floor_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Total select-low cycles for one frame.
  function automatic int unsigned frame_cycles(input int unsigned setup,
                                               input int unsigned half,
                                               input int unsigned clks);
    return setup + 2 * clks * half;
  endfunction

endpackage

// File: rtl/sar_link_clkgen.sv
module sar_link_clkgen #(
  parameter int HALF_W     = 16,
  parameter int FRAME_CLKS = 18,
  parameter int PH_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [HALF_W-1:0] half_eff,
  output logic              sclk_hi,
  output logic              rise_ev,
  output logic              fall_ev,
  output logic              last_ev,
  output logic [PH_W-1:0]   clk_num
);
  localparam int PH_LAST = 2 * FRAME_CLKS - 1;

  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] hcnt;
  logic [PH_W-1:0]   ph;
  logic              tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      hcnt   <= '0;
      ph     <= '0;
    end else if (load) begin
      half_q <= half_eff;
      hcnt   <= half_eff - 1'b1;
      ph     <= '0;
    end else if (run) begin
      if (hcnt == '0) begin
        hcnt <= half_q - 1'b1;
        ph   <= (int'(ph) == PH_LAST) ? '0 : ph + 1'b1;
      end else begin
        hcnt <= hcnt - 1'b1;
      end
    end
  end

  assign tick    = run && (hcnt == '0);
  assign rise_ev = tick && !ph[0];
  assign fall_ev = tick && ph[0] && (int'(ph) != PH_LAST);
  assign last_ev = tick && (int'(ph) == PH_LAST);
  assign sclk_hi = ph[0];
  assign clk_num = ph >> 1;

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ph) <= PH_LAST); // R2

endmodule

// File: rtl/sar_link_seq.sv
module sar_link_seq
  import sar_link_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              auto_en,
  input  logic [CNT_W-1:0]  setup_eff,
  input  logic [CNT_W-1:0]  gap_eff,
  input  logic [RATE_W-1:0] rate_period,
  input  logic              last_ev,
  output logic              frame_start,
  output logic              load,
  output logic              run,
  output logic              cs_n,
  output logic              busy,
  output logic              result_valid
);
  link_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic [RATE_W-1:0] rcnt;
  logic              rate_due;

  assign rate_due    = ({1'b0, rcnt} + 1'b1) >= {1'b0, rate_period};
  assign frame_start = (st == LK_IDLE) && (start || (auto_en && rate_due));
  assign load        = (st == LK_SETUP) && (cnt == setup_eff - 1'b1);
  assign run         = (st == LK_RUN);
  assign cs_n        = !((st == LK_SETUP) || (st == LK_RUN));
  assign busy        = (st != LK_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= LK_IDLE;
      cnt          <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= last_ev;
      unique case (st)
        LK_IDLE: if (frame_start) begin
          st  <= LK_SETUP;
          cnt <= '0;
        end
        LK_SETUP: if (load) st <= LK_RUN;
                  else      cnt <= cnt + 1'b1;
        LK_RUN: if (last_ev) begin
          st  <= LK_GAP;
          cnt <= '0;
        end
        LK_GAP: if (cnt == gap_eff - 1'b1) st <= LK_IDLE;
                else                       cnt <= cnt + 1'b1;
        default: st <= LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rcnt <= '1;
    else if (frame_start)        rcnt <= '0;
    else if (rcnt != {RATE_W{1'b1}}) rcnt <= rcnt + 1'b1;
  end

  AST_CS_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!busy)); // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R6
  AST_VALID_WITH_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && $past(!cs_n))); // R6
  AST_CS_RISE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy); // R7

endmodule

// File: rtl/sar_link_shifter.sv
module sar_link_shifter #(
  parameter int DATA_W = 12,
  parameter int CMD_W  = 4,
  parameter int PH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              last_ev,
  input  logic [PH_W-1:0]   clk_num,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] result
);
  localparam int FIRST_DATA = CMD_W + 1;
  localparam int LAST_DATA  = CMD_W + DATA_W;

  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] sh;
  logic              take_bit;

  // Command bit for clock index j (0-based), MSB first, zero afterwards.
  function automatic logic cmd_bit(input logic [CMD_W-1:0] c, input int j);
    if (j < CMD_W) return c[CMD_W-1-j];
    return 1'b0;
  endfunction

  assign take_bit = rise_ev && (int'(clk_num) >= FIRST_DATA)
                            && (int'(clk_num) <= LAST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mosi   <= 1'b0;
      sh     <= '0;
      result <= '0;
    end else begin
      if (frame_start) begin
        cmd_q <= cmd;
        mosi  <= cmd[CMD_W-1];
      end else if (fall_ev) begin
        mosi <= cmd_bit(cmd_q, int'(clk_num) + 1);
      end
      if (take_bit) sh <= {sh[DATA_W-2:0], miso};
      if (last_ev)  result <= sh;
    end
  end

  AST_RESULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $past(last_ev)); // R5

endmodule

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl
  import sar_link_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int CMD_W      = 4,
  parameter int FRAME_CLKS = 18,
  parameter int HALF_W     = 16,
  parameter int MIN_HALF   = 35,
  parameter int MAX_HALF   = 6250,
  parameter int CNT_W      = 8,
  parameter int RATE_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              auto_en,
  input  logic              cpol,
  input  logic [HALF_W-1:0] half_div,
  input  logic [CNT_W-1:0]  cs_setup,
  input  logic [CNT_W-1:0]  cs_gap,
  input  logic [RATE_W-1:0] rate_period,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              miso,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_valid
);
  localparam int PH_W = $clog2(2 * FRAME_CLKS);

  logic [HALF_W-1:0] half_eff;
  logic [CNT_W-1:0]  setup_eff, gap_eff;
  logic              frame_start, load, run;
  logic              sclk_hi, rise_ev, fall_ev, last_ev;
  logic [PH_W-1:0]   clk_num;
  logic              cpol_q;

  assign half_eff  = HALF_W'(clamp_u(int'(half_div), MIN_HALF, MAX_HALF));
  assign setup_eff = CNT_W'(floor_one(int'(cs_setup)));
  assign gap_eff   = CNT_W'(floor_one(int'(cs_gap)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cpol_q <= 1'b0;
    else if (!busy) cpol_q <= cpol;
  end

  assign sclk = run ? sclk_hi : cpol_q;

  sar_link_seq #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_en(auto_en),
    .setup_eff(setup_eff), .gap_eff(gap_eff), .rate_period(rate_period),
    .last_ev(last_ev), .frame_start(frame_start), .load(load), .run(run),
    .cs_n(cs_n), .busy(busy), .result_valid(result_valid));

  sar_link_clkgen #(.HALF_W(HALF_W), .FRAME_CLKS(FRAME_CLKS), .PH_W(PH_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run), .half_eff(half_eff),
    .sclk_hi(sclk_hi), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .last_ev(last_ev), .clk_num(clk_num));

  sar_link_shifter #(.DATA_W(DATA_W), .CMD_W(CMD_W), .PH_W(PH_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmd(cmd),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .last_ev(last_ev),
    .clk_num(clk_num), .miso(miso), .mosi(mosi), .result(result));

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sclk)); // R4
  AST_SCLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $stable(cpol_q)) |-> $stable(sclk)); // R2

endmodule

// File: tb/sar_link_ctrl_tb.sv
module sar_link_ctrl_tb;
  localparam int MINH = 3;
  localparam int MAXH = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_i = 0, auto_i = 0, cpol_i = 0, miso = 0;
  logic [15:0] half_i = 16'd4;
  logic [7:0]  setup_i = 8'd2, gap_i = 8'd3;
  logic [19:0] rate_i = 20'd300;
  logic [3:0]  cmd_i = 4'h0;
  logic        sclk, cs_n, mosi, busy, result_valid;
  logic [11:0] result;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sar_link_ctrl #(.MIN_HALF(MINH), .MAX_HALF(MAXH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_i), .auto_en(auto_i), .cpol(cpol_i),
    .half_div(half_i), .cs_setup(setup_i), .cs_gap(gap_i), .rate_period(rate_i),
    .cmd(cmd_i), .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .busy(busy), .result(result), .result_valid(result_valid));

  // Converter responder: null bit at rise 5, code MSB first at rises 6..17.
  logic [11:0] adc_code = 12'h000;
  logic [3:0]  cmd_seen = 4'h0;
  int          adc_rises = 0;
  always @(negedge cs_n) begin adc_rises = 0; miso = 1'b0; end
  always @(posedge sclk) if (!cs_n) begin
    adc_rises = adc_rises + 1;
    if (adc_rises <= 4) cmd_seen[4 - adc_rises] = mosi;
  end
  always @(negedge sclk) if (!cs_n) begin
    int nx;
    nx = adc_rises + 1;
    if (nx >= 6 && nx <= 17) miso = adc_code[17 - nx];
    else                     miso = 1'b0;
  end

  // Monitor, sampling away from the active edge.
  int cyc = 0, t_cs = 0, t_cs_prev = 0, t_csr = 0, t_first = 0, t_rise = 0, t_valid = 0;
  int nr = 0, nvalid = 0, cs_falls = 0, spacing_bad = 0, pulse_bad = 0, half_exp = 4;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0;
  logic [11:0] res_seen = '0;
  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      t_cs_prev = t_cs; t_cs = cyc; nr = 0; spacing_bad = 0; cs_falls++;
    end
    if (!prev_cs && cs_n) t_csr = cyc;
    if (!prev_sclk && sclk && !cs_n) begin
      if (nr == 0) t_first = cyc;
      else if (cyc - t_rise != 2 * half_exp) spacing_bad++;
      t_rise = cyc; nr++;
    end
    if (result_valid) begin
      nvalid++; t_valid = cyc; res_seen = result;
      if (prev_valid) pulse_bad++;
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_valid = result_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_h(input int h);
    return (h < MINH) ? MINH : ((h > MAXH) ? MAXH : h);
  endfunction
  function automatic int one_min(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic do_frame(input bit pol, input int hreq, input int sreq,
                          input logic [11:0] code_v, input logic [3:0] cmd_v);
    int he, se, f0, nv0, i;
    he = clamp_h(hreq); se = one_min(sreq);
    @(negedge clk);
    cpol_i = pol; half_i = 16'(hreq); setup_i = 8'(sreq); cmd_i = cmd_v;
    adc_code = code_v; half_exp = he;
    repeat (3) @(negedge clk);
    chk(sclk == pol, "R2 idle level", sclk, pol);
    f0 = cs_falls; nv0 = nvalid;
    start_i = 1; @(negedge clk); start_i = 0;
    repeat (4) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;   // R8: ignored while busy
    i = 0;
    while (nvalid == nv0 && i < 4000) begin @(posedge clk); i++; end
    @(posedge clk);
    chk(res_seen == code_v, "R5 result", res_seen, code_v);
    chk(t_first - t_cs == se + he, "R3 first rise", t_first - t_cs, se + he);
    chk(t_valid - t_cs == se + 36 * he, "R3 frame length", t_valid - t_cs, se + 36 * he);
    chk(nr == 18, "R2 rise count", nr, 18);
    chk(spacing_bad == 0, "R1 rise spacing", spacing_bad, 0);
    chk(cmd_seen == cmd_v, "R4 command bits", cmd_seen, cmd_v);
    chk(t_csr == t_valid, "R6 valid at cs rise", t_csr, t_valid);
    chk(pulse_bad == 0, "R6 single pulse", pulse_bad, 0);
    repeat (one_min(int'(gap_i)) + 4) @(negedge clk);
    chk(cs_falls == f0 + 1, "R8 start ignored while busy", cs_falls - f0, 1);
    chk(!busy && sclk == pol, "R2 idle after frame", {busy, sclk}, {1'b0, pol});
  endtask

  task automatic wait_falls(input int n);
    int f0, i;
    f0 = cs_falls; i = 0;
    while (cs_falls < f0 + n && i < 6000) begin @(posedge clk); i++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R3 reset cs_n", cs_n, 1);
    chk(busy == 1'b0, "R3 reset busy", busy, 0);
    chk(result_valid == 1'b0, "R3 reset valid", result_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      int hs[5] = '{1, 3, 5, 20, 27};
      for (int k = 0; k < 5; k++) begin
        logic [11:0] c;
        c = 12'hA5C ^ 12'(hs[k] * 263 + p * 1111);
        do_frame(p[0], hs[k], k % 3 * 2, c, {1'b1, p[0], hs[k][0], 1'b1});
      end
      do_frame(p[0], 3, 1, 12'h000, 4'b1000);
      do_frame(p[0], 3, 1, 12'hFFF, 4'b1111);
    end
    // Auto retrigger, R9
    @(negedge clk);
    cpol_i = 0; half_i = 16'd4; setup_i = 8'd2; gap_i = 8'd3; half_exp = 4;
    rate_i = 20'd300; auto_i = 1;
    wait_falls(3);
    chk(t_cs - t_cs_prev == 300, "R9 rate spacing", t_cs - t_cs_prev, 300);
    @(negedge clk); rate_i = 20'd10;
    wait_falls(3);
    chk(t_cs - t_cs_prev == 2 + 144 + 3 + 1, "R9 frame-bound spacing",
        t_cs - t_cs_prev, 150);
    // Held start, R7
    @(negedge clk); auto_i = 0; gap_i = 8'd6; start_i = 1;
    wait_falls(3);
    chk(t_cs - t_csr == 7, "R7 disable gap", t_cs - t_csr, 7);
    chk(res_seen == adc_code, "R5 result in back-to-back frames", res_seen, adc_code);
    @(negedge clk); start_i = 0;
    repeat (200) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1; vectors++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule